// File: doc/BRIEF.md
# Time-Aligned Event Generator

This block drives one output line from a running time-of-day value kept elsewhere as whole seconds plus nanoseconds. Once armed, it holds an absolute next-edge time and compares it with the incoming time every timer clock. When the time reaches or passes that target, an edge fires. Because edges follow absolute time and not a free-running count, the output stays in phase with the time of day after the time engine has been trimmed or stepped. Downstream parts can use it as a time-alignment reference.

Three modes are supported. The pulse-per-second mode fires on every seconds rollover. The periodic mode fires once per programmed period, given in nanoseconds. The clock mode starts at the programmed time and then outputs a square wave at the base rate divided by an integer N. The timer clock runs at twice the base rate, so the base rate is half the timer clock. In both pulse modes the pulse width is programmed in timer ticks. Configuration is held steady while the enable is high.

Top module: `tod_event_gen`

## Requirements
- R1: After reset, and in the cycle after any cycle in which `cfgEnable` is low, `evOut` is low. While the generator is disabled, the time of day passing any start time or edge time leaves `evOut` low.
- R2: Raising `cfgEnable` loads the start time at the next clock edge. The first comparison happens at the edge after that. If the start time is already in the past at that edge, `evOut` is high in the second cycle after enable was first sampled.
- R3: With `cfgMode` = 2 (periodic), the k-th edge (k = 0, 1, …) fires at the first clock edge where the time of day is at or beyond start + k·period. The nanoseconds sum carries into seconds at 1,000,000,000. Each rising edge of `evOut` appears in the cycle right after that clock edge.
- R4: With `cfgMode` = 1 (pulse per second), the first edge time is the start time rounded up to a whole second. Each later edge comes exactly one second after the previous one, so every pulse starts when the time of day crosses a seconds rollover.
- R5: In both pulse modes, each pulse stays high for exactly `cfgWidth` timer cycles. A width of 0 is treated as 1. An edge that fires while a pulse is active restarts the width count.
- R6: With `cfgMode` = 0 (clock), `evOut` rises when the time of day first reaches the start time. It then alternates N cycles high and N cycles low, where N = `cfgDivN` (1 to 255, with 0 treated as 1). The output period is therefore N base cycles, with an exact 50 % duty cycle. N = 1 reproduces the base rate.
- R7: With `cfgMode` = 3, the generator stays idle and `evOut` stays low whatever the time of day does.
- R8: Dropping `cfgEnable` while a pulse is high forces `evOut` low in the next cycle. Re-enabling re-arms the generator from the programmed start time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock, twice the base rate |
| rstN | input | 1 | Synchronous active-low reset |
| todSec | input | SEC_W | Time of day, whole seconds |
| todNs | input | NS_W | Time of day, nanoseconds (below 1e9) |
| cfgEnable | input | 1 | Arms the generator |
| cfgMode | input | 2 | 0 clock, 1 pulse per second, 2 periodic, 3 off |
| cfgDivN | input | DIV_W | Clock-mode divider N |
| cfgPeriodNs | input | NS_W | Periodic-mode period in ns (1 to 999,999,999) |
| cfgWidth | input | WIDTH_W | Pulse width in timer cycles |
| cfgStartSec | input | SEC_W | Start time, seconds |
| cfgStartNs | input | NS_W | Start time, nanoseconds |
| evOut | output | 1 | Generated event or clock output |

## Verification
The checker assumes the configuration fields are only rewritten while `cfgEnable` is low. It also assumes the time of day only moves forward, with nanoseconds below one billion. The run-length checks on the clock wave and on pulse widths rely on both of these. The bench follows the same rules: it drops enable for two cycles before every reconfiguration, and it advances time by 4 ns per clock. The only other time changes are forward jumps that stop short of the next pending edge, so no edge is skipped and no wave is cut short.

// File: rtl/evgen_pkg.sv
package evgen_pkg;

  // Output mode selection as seen on the cfgMode port
  typedef enum logic [1:0] {
    MODE_CLOCK  = 2'd0,
    MODE_PPS    = 2'd1,
    MODE_PERIOD = 2'd2,
    MODE_OFF    = 2'd3
  } evMode_e;

  // Control state
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_CLKRUN = 2'd2
  } evState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;    // drop output, stop wave
    logic loadStart;   // load next-edge time from start time
    logic advance;     // step next-edge time by one period
    logic startPulse;  // begin a pulse of programmed width
    logic startDiv;    // begin the divided clock wave
  } evStrobe_t;

endpackage

// File: rtl/evgen_sched.sv
module evgen_sched #(
  parameter int          SEC_W      = 32,
  parameter int          NS_W       = 30,
  parameter int unsigned NS_PER_SEC = 1000000000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStart,
  input  logic             advance,
  input  logic             ppsMode,
  input  logic [NS_W-1:0]  cfgPeriodNs,
  input  logic [SEC_W-1:0] cfgStartSec,
  input  logic [NS_W-1:0]  cfgStartNs,
  input  logic [SEC_W-1:0] todSec,
  input  logic [NS_W-1:0]  todNs,
  output logic             edgeDue
);

  localparam int SUM_W = NS_W + 1;
  localparam logic [SUM_W-1:0] WRAP_NS = SUM_W'(NS_PER_SEC);

  logic [SEC_W-1:0] nextSec;
  logic [NS_W-1:0]  nextNs;

  // start time, rounded up to a whole second in pulse-per-second mode
  logic [SEC_W-1:0] loadSec;
  logic [NS_W-1:0]  loadNs;

  always_comb begin
    loadSec = cfgStartSec;
    loadNs  = cfgStartNs;
    if (ppsMode) begin
      loadNs = '0;
      if (cfgStartNs != '0) begin
        loadSec = cfgStartSec + SEC_W'(1);
      end
    end
  end

  // next-edge time plus one period, with nanosecond carry
  logic [SUM_W-1:0] nsSum;
  logic             nsWrap;
  logic [SEC_W-1:0] stepSec;
  logic [NS_W-1:0]  stepNs;

  always_comb begin
    nsSum  = {1'b0, nextNs} + {1'b0, cfgPeriodNs};
    nsWrap = (nsSum >= WRAP_NS);
    if (ppsMode) begin
      stepSec = nextSec + SEC_W'(1);
      stepNs  = nextNs;
    end else begin
      stepSec = nextSec + SEC_W'(nsWrap);
      stepNs  = nsWrap ? NS_W'(nsSum - WRAP_NS) : NS_W'(nsSum);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextSec <= '0;
      nextNs  <= '0;
    end else if (loadStart) begin
      nextSec <= loadSec;
      nextNs  <= loadNs;
    end else if (advance) begin
      nextSec <= stepSec;
      nextNs  <= stepNs;
    end
  end

  // reached or passed: seconds first, then nanoseconds
  always_comb begin
    edgeDue = (todSec > nextSec) || ((todSec == nextSec) && (todNs >= nextNs));
  end

endmodule

// File: rtl/evgen_wave.sv
module evgen_wave #(
  parameter int DIV_W   = 8,
  parameter int WIDTH_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clearAll,
  input  logic               startPulse,
  input  logic               startDiv,
  input  logic [DIV_W-1:0]   cfgDivN,
  input  logic [WIDTH_W-1:0] cfgWidth,
  output logic               waveOut
);

  logic [WIDTH_W-1:0] pulseCnt;
  logic [WIDTH_W-1:0] widthEff;
  logic [DIV_W-1:0]   divCnt;
  logic [DIV_W-1:0]   divEff;
  logic               divActive;
  logic               phase;

  always_comb begin
    widthEff = (cfgWidth == '0) ? WIDTH_W'(1) : cfgWidth;
    divEff   = (cfgDivN == '0) ? DIV_W'(1) : cfgDivN;
  end

  // pulse width counter: high while non-zero
  always_ff @(posedge clk) begin
    if (!rstN || clearAll) begin
      pulseCnt <= '0;
    end else if (startPulse) begin
      pulseCnt <= widthEff;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - WIDTH_W'(1);
    end
  end

  // divided clock: phase flips every divEff timer cycles
  always_ff @(posedge clk) begin
    if (!rstN || clearAll) begin
      divActive <= 1'b0;
      phase     <= 1'b0;
      divCnt    <= '0;
    end else if (startDiv) begin
      divActive <= 1'b1;
      phase     <= 1'b1;
      divCnt    <= '0;
    end else if (divActive) begin
      if (divCnt == divEff - DIV_W'(1)) begin
        divCnt <= '0;
        phase  <= ~phase;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  always_comb begin
    waveOut = divActive ? phase : (pulseCnt != '0);
  end

endmodule

// File: rtl/evgen_dp.sv
module evgen_dp
  import evgen_pkg::*;
#(
  parameter int          SEC_W      = 32,
  parameter int          NS_W       = 30,
  parameter int          DIV_W      = 8,
  parameter int          WIDTH_W    = 16,
  parameter int unsigned NS_PER_SEC = 1000000000
) (
  input  logic               clk,
  input  logic               rstN,
  input  evStrobe_t          strobe,
  input  logic [1:0]         cfgMode,
  input  logic [DIV_W-1:0]   cfgDivN,
  input  logic [NS_W-1:0]    cfgPeriodNs,
  input  logic [WIDTH_W-1:0] cfgWidth,
  input  logic [SEC_W-1:0]   cfgStartSec,
  input  logic [NS_W-1:0]    cfgStartNs,
  input  logic [SEC_W-1:0]   todSec,
  input  logic [NS_W-1:0]    todNs,
  output logic               edgeDue,
  output logic               evOut
);

  logic ppsMode;
  assign ppsMode = (evMode_e'(cfgMode) == MODE_PPS);

  evgen_sched #(
    .SEC_W     (SEC_W),
    .NS_W      (NS_W),
    .NS_PER_SEC(NS_PER_SEC)
  ) u_sched (
    .clk        (clk),
    .rstN       (rstN),
    .loadStart  (strobe.loadStart),
    .advance    (strobe.advance),
    .ppsMode    (ppsMode),
    .cfgPeriodNs(cfgPeriodNs),
    .cfgStartSec(cfgStartSec),
    .cfgStartNs (cfgStartNs),
    .todSec     (todSec),
    .todNs      (todNs),
    .edgeDue    (edgeDue)
  );

  evgen_wave #(
    .DIV_W  (DIV_W),
    .WIDTH_W(WIDTH_W)
  ) u_wave (
    .clk       (clk),
    .rstN      (rstN),
    .clearAll  (strobe.clearAll),
    .startPulse(strobe.startPulse),
    .startDiv  (strobe.startDiv),
    .cfgDivN   (cfgDivN),
    .cfgWidth  (cfgWidth),
    .waveOut   (evOut)
  );

endmodule

// File: rtl/evgen_ctrl.sv
module evgen_ctrl
  import evgen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEnable,
  input  logic [1:0] cfgMode,
  input  logic       edgeDue,
  output evStrobe_t  strobe
);

  evState_e state, stateNext;
  evMode_e  mode;

  assign mode = evMode_e'(cfgMode);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (!cfgEnable) begin
      strobe.clearAll = 1'b1;
      stateNext       = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (mode != MODE_OFF) begin
            strobe.loadStart = 1'b1;
            stateNext        = ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (edgeDue) begin
            if (mode == MODE_CLOCK) begin
              strobe.startDiv = 1'b1;
              stateNext       = ST_CLKRUN;
            end else begin
              strobe.advance    = 1'b1;
              strobe.startPulse = 1'b1;
            end
          end
        end
        ST_CLKRUN: begin
          stateNext = ST_CLKRUN;
        end
        default: begin
          stateNext = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

endmodule

// File: rtl/tod_event_gen.sv
module tod_event_gen
  import evgen_pkg::*;
#(
  parameter int          SEC_W      = 32,
  parameter int          NS_W       = 30,
  parameter int          DIV_W      = 8,
  parameter int          WIDTH_W    = 16,
  parameter int unsigned NS_PER_SEC = 1000000000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEC_W-1:0]   todSec,
  input  logic [NS_W-1:0]    todNs,
  input  logic               cfgEnable,
  input  logic [1:0]         cfgMode,
  input  logic [DIV_W-1:0]   cfgDivN,
  input  logic [NS_W-1:0]    cfgPeriodNs,
  input  logic [WIDTH_W-1:0] cfgWidth,
  input  logic [SEC_W-1:0]   cfgStartSec,
  input  logic [NS_W-1:0]    cfgStartNs,
  output logic               evOut
);

  evStrobe_t strobe;
  logic      edgeDue;

  evgen_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgEnable(cfgEnable),
    .cfgMode  (cfgMode),
    .edgeDue  (edgeDue),
    .strobe   (strobe)
  );

  evgen_dp #(
    .SEC_W     (SEC_W),
    .NS_W      (NS_W),
    .DIV_W     (DIV_W),
    .WIDTH_W   (WIDTH_W),
    .NS_PER_SEC(NS_PER_SEC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgMode    (cfgMode),
    .cfgDivN    (cfgDivN),
    .cfgPeriodNs(cfgPeriodNs),
    .cfgWidth   (cfgWidth),
    .cfgStartSec(cfgStartSec),
    .cfgStartNs (cfgStartNs),
    .todSec     (todSec),
    .todNs      (todNs),
    .edgeDue    (edgeDue),
    .evOut      (evOut)
  );

endmodule

// File: rtl/tod_event_gen_chk.sv
module tod_event_gen_chk #(
  parameter int DIV_W   = 8,
  parameter int WIDTH_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgEnable,
  input logic [1:0]         cfgMode,
  input logic [DIV_W-1:0]   cfgDivN,
  input logic [WIDTH_W-1:0] cfgWidth,
  input logic               evOut
);

  localparam int RUN_W = ((WIDTH_W > DIV_W) ? WIDTH_W : DIV_W) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic             prevOut;
  logic             sawRise;
  logic [RUN_W-1:0] runLen;   // length of the output run that ended last cycle
  logic [RUN_W-1:0] widthEff;
  logic [RUN_W-1:0] divEff;

  always_comb begin
    widthEff = (cfgWidth == '0) ? RUN_W'(1) : RUN_W'(cfgWidth);
    divEff   = (cfgDivN == '0) ? RUN_W'(1) : RUN_W'(cfgDivN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevOut <= 1'b0;
      sawRise <= 1'b0;
      runLen  <= '0;
    end else begin
      prevOut <= evOut;
      sawRise <= cfgEnable && (sawRise || (evOut && !prevOut));
      if (evOut != prevOut) begin
        runLen <= RUN_W'(1);
      end else if (runLen != RUN_MAX) begin
        runLen <= runLen + RUN_W'(1);
      end
    end
  end

  // R1
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> !evOut);

  // R2
  rise_after_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evOut) |-> ($past(cfgEnable) && $past(cfgEnable, 2)));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && $past(cfgEnable) && (cfgMode == 2'd1 || cfgMode == 2'd2) && $fell(evOut))
      |-> (runLen >= widthEff));

  // R6
  clock_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && cfgMode == 2'd0 && sawRise) |-> (runLen <= divEff));

  // R7
  off_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd3 && $past(cfgMode) == 2'd3) |-> !evOut);

endmodule

bind tod_event_gen tod_event_gen_chk #(
  .DIV_W  (DIV_W),
  .WIDTH_W(WIDTH_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgEnable(cfgEnable),
  .cfgMode  (cfgMode),
  .cfgDivN  (cfgDivN),
  .cfgWidth (cfgWidth),
  .evOut    (evOut)
);

// File: tb/tod_event_gen_bench.sv
module tod_event_gen_bench;

  localparam int     SEC_W   = 32;
  localparam int     NS_W    = 30;
  localparam int     DIV_W   = 8;
  localparam int     WIDTH_W = 16;
  localparam longint NS_SEC  = 64'd1000000000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [SEC_W-1:0]   todSec;
  logic [NS_W-1:0]    todNs;
  logic               cfgEnable;
  logic [1:0]         cfgMode;
  logic [DIV_W-1:0]   cfgDivN;
  logic [NS_W-1:0]    cfgPeriodNs;
  logic [WIDTH_W-1:0] cfgWidth;
  logic [SEC_W-1:0]   cfgStartSec;
  logic [NS_W-1:0]    cfgStartNs;
  logic               evOut;

  tod_event_gen u_tod_event_gen (
    .clk        (clk),
    .rstN       (rstN),
    .todSec     (todSec),
    .todNs      (todNs),
    .cfgEnable  (cfgEnable),
    .cfgMode    (cfgMode),
    .cfgDivN    (cfgDivN),
    .cfgPeriodNs(cfgPeriodNs),
    .cfgWidth   (cfgWidth),
    .cfgStartSec(cfgStartSec),
    .cfgStartNs (cfgStartNs),
    .evOut      (evOut)
  );

  longint todTotal;   // value being driven now
  longint seenTot;    // value sampled by the last rising edge
  longint prevSeen;   // value sampled by the edge before
  logic   outNow;
  logic   lastOut;
  int     nChecks = 0;
  int     nFail = 0;
  bit     finished = 0;

  task automatic driveTod();
    todSec = SEC_W'(todTotal / NS_SEC);
    todNs  = NS_W'(todTotal % NS_SEC);
  endtask

  task automatic check(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sample between edges, then advance the time of day by one 4 ns tick
  task automatic tick();
    @(negedge clk);
    prevSeen = seenTot;
    seenTot  = todTotal;
    lastOut  = outNow;
    outNow   = evOut;
    todTotal = todTotal + 4;
    driveTod();
  endtask

  task automatic jumpTo(longint t);
    todTotal = t;
    driveTod();
  endtask

  function automatic longint roundUpSec(longint t);
    return ((t % NS_SEC) == 0) ? t : ((t / NS_SEC) + 1) * NS_SEC;
  endfunction

  task automatic arm(longint t0, longint startT, logic [1:0] mode, int per, int w, int n);
    cfgEnable = 1'b0;
    tick();
    tick();
    jumpTo(t0);
    cfgMode     = mode;
    cfgPeriodNs = NS_W'(per);
    cfgWidth    = WIDTH_W'(w);
    cfgDivN     = DIV_W'(n);
    cfgStartSec = SEC_W'(startT / NS_SEC);
    cfgStartNs  = NS_W'(startT % NS_SEC);
    cfgEnable   = 1'b1;
  endtask

  task automatic runPulses(longint t0, longint startT, int per, int w, int edges,
                           bit pps, string tag);
    longint expEdge;
    int     k = 0;
    int     highLen = 0;
    int     guard = 0;
    int     widthExp;
    widthExp = (w == 0) ? 1 : w;
    arm(t0, startT, pps ? 2'd1 : 2'd2, per, w, 1);
    expEdge = pps ? roundUpSec(startT) : startT;
    while (k < edges && guard < 30000) begin
      tick();
      guard++;
      if (outNow && !lastOut) begin
        check(prevSeen < expEdge && expEdge <= seenTot, tag, seenTot, expEdge);
        expEdge = expEdge + (pps ? NS_SEC : longint'(per));
        k++;
        highLen = 1;
      end else if (outNow) begin
        highLen++;
      end else if (lastOut) begin
        check(highLen == widthExp, "R5 width", highLen, widthExp);
      end
      if (!outNow && (expEdge - todTotal) > 4000) begin
        jumpTo(expEdge - 400);
      end
    end
    check(k == edges, tag, k, edges);
  endtask

  task automatic runClock(longint t0, longint startT, int n, int runs);
    int guard = 0;
    int runLen = 1;
    int done = 0;
    int nExp;
    nExp = (n == 0) ? 1 : n;
    arm(t0, startT, 2'd0, 1000, 1, n);
    while (!(outNow && !lastOut) && guard < 20000) begin
      tick();
      guard++;
    end
    check(prevSeen < startT && startT <= seenTot, "R6 first edge", seenTot, startT);
    while (done < runs && guard < 20000) begin
      tick();
      guard++;
      if (outNow == lastOut) begin
        runLen++;
      end else begin
        check(runLen == nExp, "R6 run length", runLen, nExp);
        done++;
        runLen = 1;
      end
    end
    check(done == runs, "R6 runs seen", done, runs);
  endtask

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'd20611);
    cfgEnable   = 1'b0;
    cfgMode     = 2'd2;
    cfgDivN     = DIV_W'(1);
    cfgPeriodNs = NS_W'(1000);
    cfgWidth    = WIDTH_W'(1);
    cfgStartSec = '0;
    cfgStartNs  = '0;
    todTotal    = 64'd3000000000;
    seenTot     = todTotal;
    prevSeen    = todTotal;
    outNow      = 1'b0;
    lastOut     = 1'b0;
    driveTod();

    repeat (5) @(negedge clk);
    check(evOut == 1'b0, "R1 reset", evOut, 0);
    rstN = 1'b1;
    repeat (3) tick();
    check(outNow == 1'b0, "R1 after reset", outNow, 0);

    // R2: start already in the past fires two cycles after enable
    arm(64'd7000000000, 64'd7000000000 - 1000, 2'd2, 5000, 3, 1);
    tick();
    check(outNow == 1'b0, "R2 load cycle", outNow, 0);
    tick();
    check(outNow == 1'b1, "R2 late start", outNow, 1);

    // R3: random periodic runs, often crossing a seconds rollover
    for (int i = 0; i < 3; i++) begin
      longint t0;
      int per;
      int w;
      t0  = longint'($urandom_range(10, 20)) * NS_SEC - longint'($urandom_range(0, 6000));
      per = int'($urandom_range(300, 3000));
      w   = int'($urandom_range(0, per / 16));
      runPulses(t0, t0 + longint'($urandom_range(50, 1000)), per, w, 5, 1'b0, "R3 edge");
    end
    // R3 and R5: width 0 with a directed carry into seconds
    runPulses(64'd8999999000, 64'd8999999500, 999, 0, 4, 1'b0, "R3 carry");

    // R4: past start rounds up to the next whole second
    runPulses(64'd4999999000, 64'd4500000000, 1000, 10, 3, 1'b1, "R4 pps");

    // R6: directed and random dividers
    runClock(64'd2000000000, 64'd2000000200, 1, 6);
    runClock(64'd2000000000, 64'd2000000200, 2, 6);
    runClock(64'd2000000000, 64'd2000000203, 3, 6);
    runClock(64'd2000000000, 64'd2000000100, 0, 4);
    runClock(64'd2000000000, 64'd2000000100, 255, 4);
    for (int i = 0; i < 3; i++) begin
      runClock(64'd2500000000, 64'd2500000000 + longint'($urandom_range(10, 900)),
               int'($urandom_range(1, 40)), 6);
    end

    // R7: off mode stays low as time passes the start
    begin
      bit sawHigh = 1'b0;
      arm(64'd3000000000, 64'd3000000100, 2'd3, 200, 5, 1);
      repeat (300) begin
        tick();
        if (outNow) sawHigh = 1'b1;
      end
      check(!sawHigh, "R7 off mode", sawHigh, 0);
    end

    // R8: disable mid-pulse, stay low while disabled, then re-arm
    begin
      int guard = 0;
      bit sawHigh = 1'b0;
      arm(64'd3000000000, 64'd3000000200, 2'd2, 2000, 50, 1);
      while (!outNow && guard < 1000) begin
        tick();
        guard++;
      end
      repeat (5) tick();
      check(outNow == 1'b1, "R8 pulse active", outNow, 1);
      cfgEnable = 1'b0;
      tick();
      check(outNow == 1'b0, "R8 disable drop", outNow, 0);
      repeat (1200) begin
        tick();
        if (outNow) sawHigh = 1'b1;
      end
      check(!sawHigh, "R1 ignored while disabled", sawHigh, 0);
      runPulses(64'd3000010000, 64'd3000010700, 1500, 20, 3, 1'b0, "R8 rearm");
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule